// File: doc/BRIEF.md
# 64b/66b Receive Word Aligner

This block sits behind a deserializer that delivers 66-bit candidate words. Each word carries a two-bit sync header above a 64-bit payload. While the word boundary is unknown, the block looks for a long unbroken run of control-header words. That run is only present during link start-up, when the far end transmits nothing but idle codes. Whenever a word breaks the pattern, the block pulses a bit-slip request to the deserializer. It then waits a settling interval so the shifted output can stabilise before it starts counting again.

Once the run is long enough, the block declares lock and raises a ready flag. That flag is fed into the outgoing link status field. The block then forwards every aligned word, with its header, downstream through a registered stage. While locked, it tracks malformed headers over fixed windows. Too many in one window drops lock and restarts the search without a slip.

Top module: `wordsync_rx`

## Requirements
- R1: The sync header is `in_word[65:64]` and the payload is `in_word[63:0]`; header 2'b10 marks a control word, 2'b01 a data word, and 2'b00 or 2'b11 is malformed.
- R2: After reset `rx_ready`, `slip` and `out_valid` are low and the block is searching.
- R3: While searching, a valid word whose header is not 2'b10 raises `slip` for exactly one cycle, in the cycle after that word, and clears the run count.
- R4: After a slip the next 32 valid words are ignored: none of them causes a slip or counts toward lock, whatever its header.
- R5: `rx_ready` rises in the cycle after the 128th consecutive valid control-header word seen while searching.
- R6: Cycles with `in_valid` low neither advance nor break the run count, and never cause a slip.
- R7: While locked, `slip` stays low, and data or control headers keep the lock.
- R8: While locked, the 16th malformed header within one 64-word window drops `rx_ready` in the cycle after that word; the search restarts with no slip.
- R9: The malformed-header count restarts every 64 valid words, so 15 malformed headers in each of successive windows keep the lock.
- R10: `out_valid` is high in the cycle after a valid word presented while `rx_ready` was high, with `out_data` and `out_hdr` equal to that word's payload and header; otherwise `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 66 | Candidate word from the deserializer, header on top |
| in_valid | input | 1 | Candidate word strobe |
| slip | output | 1 | One-cycle bit-slip request to the deserializer |
| rx_ready | output | 1 | Lock flag, used as the receive-ready status bit |
| out_data | output | 64 | Aligned payload |
| out_hdr | output | 2 | Aligned sync header |
| out_valid | output | 1 | Aligned word strobe |

## Verification
The hardest state to reach from the ports is loss of lock. The block has to be locked first, and then the 16th malformed header must land inside a single 64-word window. A window just short of that count must instead roll over cleanly. The bench reaches this with a vector table of word runs. The table locks the block, places 15 malformed headers in one window, and fills the window with good words. It then places 15 more in the next window and adds one further malformed word. The same table opens with a slip and a settling run made of malformed headers, to show that those words are ignored.

// File: rtl/wordsync_pkg.sv
package wordsync_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_e;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

endpackage

// File: rtl/wordsync_hdr_class.sv
module wordsync_hdr_class
    import wordsync_pkg::*;
(
    input  logic [1:0] hdr,
    output logic       is_ctrl,
    output logic       is_bad
);
    // R1: equal header bits never form a legal sync header
    always_comb begin
        is_ctrl = (hdr == HDR_CTRL);
        is_bad  = ~(hdr[1] ^ hdr[0]);
    end
endmodule

// File: rtl/wordsync_fsm.sv
module wordsync_fsm
    import wordsync_pkg::*;
#(
    parameter int LOCK_WORDS   = 128,
    parameter int SETTLE_WORDS = 32,
    parameter int WIN_WORDS    = 64,
    parameter int BAD_LIMIT    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_valid,
    input  logic is_ctrl,
    input  logic is_bad,
    output logic slip,
    output logic locked
);
    localparam int RUN_W = $clog2(LOCK_WORDS + 1);
    localparam int SET_W = $clog2(SETTLE_WORDS + 1);
    localparam int WIN_W = $clog2(WIN_WORDS + 1);
    localparam int BAD_W = $clog2(BAD_LIMIT + 1);

    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_WORDS - 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_WORDS - 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_WORDS - 1);
    localparam logic [BAD_W-1:0] BAD_LAST = BAD_W'(BAD_LIMIT - 1);

    typedef struct packed {
        sync_state_e      state;
        logic [RUN_W-1:0] run;
        logic [SET_W-1:0] settle;
        logic [WIN_W-1:0] win;
        logic [BAD_W-1:0] bad;
        logic             slip;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slip = 1'b0;
        unique case (st_q.state)
            ST_SEARCH: begin
                if (word_valid) begin
                    if (is_ctrl) begin
                        if (st_q.run == RUN_LAST) begin
                            st_d.state = ST_LOCKED;
                            st_d.run   = '0;
                            st_d.win   = '0;
                            st_d.bad   = '0;
                        end else begin
                            st_d.run = st_q.run + 1'b1;
                        end
                    end else begin
                        st_d.slip   = 1'b1;
                        st_d.state  = ST_SETTLE;
                        st_d.run    = '0;
                        st_d.settle = '0;
                    end
                end
            end
            ST_SETTLE: begin
                if (word_valid) begin
                    if (st_q.settle == SET_LAST) begin
                        st_d.state = ST_SEARCH;
                        st_d.run   = '0;
                    end else begin
                        st_d.settle = st_q.settle + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (word_valid) begin
                    if (is_bad && (st_q.bad == BAD_LAST)) begin
                        st_d.state = ST_SEARCH;
                        st_d.run   = '0;
                    end else if (st_q.win == WIN_LAST) begin
                        st_d.win = '0;
                        st_d.bad = '0;
                    end else begin
                        st_d.win = st_q.win + 1'b1;
                        st_d.bad = st_q.bad + BAD_W'(is_bad);
                    end
                end
            end
            default: begin
                st_d.state = ST_SEARCH;
                st_d.run   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state  <= ST_SEARCH;
            st_q.run    <= '0;
            st_q.settle <= '0;
            st_q.win    <= '0;
            st_q.bad    <= '0;
            st_q.slip   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slip   = st_q.slip;
    assign locked = (st_q.state == ST_LOCKED);
endmodule

// File: rtl/wordsync_out_stage.sv
module wordsync_out_stage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W+1:0] word_in,
    input  logic              valid_in,
    input  logic              locked,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_hdr,
    output logic              out_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [1:0]        hdr;
        logic              valid;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = valid_in && locked;
        if (valid_in && locked) begin
            o_d.data = word_in[DATA_W-1:0];
            o_d.hdr  = word_in[DATA_W+1:DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_data  = o_q.data;
    assign out_hdr   = o_q.hdr;
    assign out_valid = o_q.valid;
endmodule

// File: rtl/wordsync_rx.sv
module wordsync_rx #(
    parameter int DATA_W       = 64,
    parameter int LOCK_WORDS   = 128,
    parameter int SETTLE_WORDS = 32,
    parameter int WIN_WORDS    = 64,
    parameter int BAD_LIMIT    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W+1:0] in_word,
    input  logic              in_valid,
    output logic              slip,
    output logic              rx_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_hdr,
    output logic              out_valid
);
    logic hdr_ctrl;
    logic hdr_bad;
    logic locked;

    wordsync_hdr_class i_class (
        .hdr     (in_word[DATA_W+1:DATA_W]),
        .is_ctrl (hdr_ctrl),
        .is_bad  (hdr_bad)
    );

    wordsync_fsm #(
        .LOCK_WORDS   (LOCK_WORDS),
        .SETTLE_WORDS (SETTLE_WORDS),
        .WIN_WORDS    (WIN_WORDS),
        .BAD_LIMIT    (BAD_LIMIT)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (in_valid),
        .is_ctrl    (hdr_ctrl),
        .is_bad     (hdr_bad),
        .slip       (slip),
        .locked     (locked)
    );

    wordsync_out_stage #(
        .DATA_W (DATA_W)
    ) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (in_word),
        .valid_in  (in_valid),
        .locked    (locked),
        .out_data  (out_data),
        .out_hdr   (out_hdr),
        .out_valid (out_valid)
    );

    assign rx_ready = locked;
endmodule

// File: rtl/wordsync_rx_chk.sv
module wordsync_rx_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W+1:0] in_word,
    input logic              in_valid,
    input logic              slip,
    input logic              rx_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        out_hdr,
    input logic              out_valid
);
    AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slip |=> !slip); // R3
    AST_SLIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> ($past(in_valid) && ($past(in_word[DATA_W+1:DATA_W]) != 2'b10))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(rx_ready) && !slip)); // R6
    AST_NO_SLIP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !slip); // R7
    AST_LOCK_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> ($past(in_valid) && ($past(in_word[DATA_W+1:DATA_W]) == 2'b10))); // R5
    AST_DROP_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ready) |-> ($past(in_valid) &&
                             ($past(in_word[DATA_W+1]) == $past(in_word[DATA_W])))); // R8
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && $past(rx_ready))); // R10
    AST_OUT_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data == $past(in_word[DATA_W-1:0])) &&
                       (out_hdr == $past(in_word[DATA_W+1:DATA_W])))); // R10
endmodule

bind wordsync_rx wordsync_rx_chk #(.DATA_W(DATA_W)) i_wordsync_rx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_word   (in_word),
    .in_valid  (in_valid),
    .slip      (slip),
    .rx_ready  (rx_ready),
    .out_data  (out_data),
    .out_hdr   (out_hdr),
    .out_valid (out_valid)
);

// File: tb/test_wordsync_rx.sv
`timescale 1ns/1ps
module test_wordsync_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [65:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        slip, rx_ready, out_valid;
    logic [63:0] out_data;
    logic [1:0]  out_hdr;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    wordsync_rx i_wordsync_rx (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .slip(slip), .rx_ready(rx_ready), .out_data(out_data),
        .out_hdr(out_hdr), .out_valid(out_valid)
    );

    // {req[3:0], words[7:0], header[1:0], ready_after, slip_seen}
    localparam int NPLAN = 13;
    localparam logic [15:0] PLAN [NPLAN] = '{
        {4'd5,  8'd40,  2'b10, 1'b0, 1'b0},  // R5 short run, no lock
        {4'd3,  8'd1,   2'b01, 1'b0, 1'b1},  // R3 data header while searching slips
        {4'd4,  8'd32,  2'b11, 1'b0, 1'b0},  // R4 malformed words during settle ignored
        {4'd5,  8'd127, 2'b10, 1'b0, 1'b0},  // R5 one short of lock
        {4'd5,  8'd1,   2'b10, 1'b1, 1'b0},  // R5 128th control word locks
        {4'd7,  8'd20,  2'b01, 1'b1, 1'b0},  // R7 data words keep lock
        {4'd8,  8'd15,  2'b11, 1'b1, 1'b0},  // R8 15 malformed in window
        {4'd9,  8'd29,  2'b10, 1'b1, 1'b0},  // R9 fill window to 64
        {4'd9,  8'd15,  2'b00, 1'b1, 1'b0},  // R9 fresh window tolerates 15
        {4'd8,  8'd1,   2'b11, 1'b0, 1'b0},  // R8 16th drops lock, no slip
        {4'd3,  8'd1,   2'b00, 1'b0, 1'b1},  // R3 search resumed, slip
        {4'd4,  8'd32,  2'b10, 1'b0, 1'b0},  // R4 settle words not counted
        {4'd5,  8'd128, 2'b10, 1'b1, 1'b0}   // R5 relock
    };

    task automatic check(input string tag, input logic ok,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] h, input logic [63:0] p);
        in_word  = {h, p};
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic saw;
        do_reset();
        // R2 reset state
        check("R2", {rx_ready, slip, out_valid} == 3'b000,
              64'({rx_ready, slip, out_valid}), 64'd0);

        for (int e = 0; e < NPLAN; e++) begin
            saw = 1'b0;
            for (int k = 0; k < int'(PLAN[e][11:4]); k++) begin
                send(PLAN[e][3:2], {32'hA5A5_0000, 16'(e), 16'(k)});
                if (slip) saw = 1'b1;
            end
            check($sformatf("R%0d ready step %0d", PLAN[e][15:12], e),
                  rx_ready == PLAN[e][1], 64'(rx_ready), 64'(PLAN[e][1]));
            check($sformatf("R%0d slip step %0d", PLAN[e][15:12], e),
                  saw == PLAN[e][0], 64'(saw), 64'(PLAN[e][0]));
        end

        // R10 and R1: forwarded payload and header while locked
        send(2'b01, 64'h0123_4567_89AB_CDEF);
        check("R10 valid", out_valid == 1'b1, 64'(out_valid), 64'd1);
        check("R10 data", out_data == 64'h0123_4567_89AB_CDEF, out_data, 64'h0123_4567_89AB_CDEF);
        check("R1 data hdr", out_hdr == 2'b01, 64'(out_hdr), 64'd1);
        send(2'b10, 64'hFEDC_BA98_7654_3210);
        check("R1 ctrl hdr", out_hdr == 2'b10, 64'(out_hdr), 64'd2);
        idle();
        check("R10 idle", out_valid == 1'b0, 64'(out_valid), 64'd0);

        // R2 reset from locked
        do_reset();
        check("R2 after lock", {rx_ready, slip, out_valid} == 3'b000,
              64'({rx_ready, slip, out_valid}), 64'd0);

        // R10 no forwarding while searching
        send(2'b10, 64'h1111);
        check("R10 unlocked", out_valid == 1'b0, 64'(out_valid), 64'd0);

        // R6 gaps do not break the run (1 word already counted)
        for (int k = 0; k < 99; k++) send(2'b10, 64'(k));
        saw = 1'b0;
        for (int k = 0; k < 10; k++) begin
            idle();
            if (slip || rx_ready) saw = 1'b1;
        end
        check("R6 gap quiet", saw == 1'b0, 64'(saw), 64'd0);
        for (int k = 0; k < 27; k++) send(2'b10, 64'(k));
        check("R6 not yet", rx_ready == 1'b0, 64'(rx_ready), 64'd0);
        send(2'b10, 64'h2222);
        check("R6 lock across gap", rx_ready == 1'b1, 64'(rx_ready), 64'd1);

        // R3 slip lasts one cycle
        do_reset();
        send(2'b01, 64'h3333);
        check("R3 pulse", slip == 1'b1, 64'(slip), 64'd1);
        idle();
        check("R3 pulse end", slip == 1'b0, 64'(slip), 64'd0);

        // R4 settle boundary: 32nd ignored, 33rd counts
        for (int k = 0; k < 31; k++) send(2'b10, 64'(k));
        send(2'b00, 64'h4444);
        check("R4 last settle word", slip == 1'b0, 64'(slip), 64'd0);
        send(2'b00, 64'h5555);
        check("R4 first search word", slip == 1'b1, 64'(slip), 64'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule